// File: doc/BRIEF.md
# Snapshot-Read Match Timer

This block is a memory-mapped system timer. A free-running 64-bit up-counter advances on ticks from a programmable prescaler. Software reads the counter coherently by issuing a snapshot command, which copies all 64 bits into a pair of shadow registers in one cycle. The shadow registers can then be read one word at a time without tearing. Software may also write either half of the live counter, to zero it at start-up or to put back a saved value.

Six 32-bit compare channels watch the low word of the counter. Each one raises its own status flag when the counter steps onto its value. Any flag whose enable bit is set drives the shared interrupt line. The last channel can also be armed as a watchdog, and it then drives a system-reset output. Access is through a plain 32-bit register bus with a write strobe, a read strobe and a byte address. Every bus access completes in one cycle. There is no back-pressure: the block accepts a write strobe on any cycle, and read data is valid on the cycle after the read strobe.

Top module: `tmr_snapshot_timer`

## Requirements
- R1: After reset the counter, the snapshot registers, the status flags, the interrupt enables, the watchdog enable and the prescaler divider are all 0. The irq and wdt_rst outputs are low.
- R2: With divider value D (word 0x2C), the counter advances once every 2*(D+1) clocks. A write to the divider restarts the prescale phase, so the first advance comes 2*(D+1) clocks after the write edge.
- R3: The counter is 64 bits wide, and the low word (0x00) carries into the high word (0x04). A write to either half loads that half, and on that cycle the write takes the place of any increment.
- R4: Writing 1 to bit 0 of word 0x30 copies the counter value of that cycle into the snapshot words 0x34 (low) and 0x38 (high). Those words hold until the next snapshot command. Word 0x30 reads as 0.
- R5: Compare channel n lives at word 0x08+4n, with n from 0 to 5. Status bit n sets when the counter increments to a value whose low 32 bits equal the channel's value. Because only the low word is compared, a match target that lies past a low-word wrap works.
- R6: A status bit does not set while the counter holds a matching value, or when the counter or the compare value is written to be equal. Only an increment onto the value counts.
- R7: Status (word 0x20, bits 5:0) is write-one-to-clear. A 1 clears that bit and a 0 leaves it unchanged. If a match and a clear hit the same bit in the same cycle, the match wins.
- R8: irq is high exactly when some status bit n and interrupt enable bit n (word 0x24, bits 5:0) are both set.
- R9: When bit 0 of word 0x28 is set, a channel 5 match raises wdt_rst. wdt_rst then stays high until reset. Channel 5 sets its status bit whether or not the watchdog is armed.
- R10: Read data for the address presented with rd_en appears on rd_data on the following cycle. Addresses that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the register (word aligned) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | OR of enabled, set status bits |
| wdt_rst | output | 1 | Sticky watchdog reset request |

## Verification
The bench counts prescaler ticks exactly over a fixed window. A prescaler that runs at D+1 instead of 2*(D+1), or that keeps its old phase after a divider write, gives a wrong snapshot count. The bench steps the low word through its wrap with channels parked at 0 and 2. A design that compares all 64 bits, or drops the carry, misses those flags or leaves the high word stale. The bench also leaves the counter sitting on a compare value, writes status with 0, and reads the snapshot after further counter writes. This catches level-sensitive matching, a clear that ignores the written bit, and a shadow register that follows the live counter. The watchdog is fired once while disarmed and once armed, which exposes a reset output that does not depend on its enable or does not stay asserted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_CH  = 6;
  localparam int WIDX_W  = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] IDX_CNT_LO = 6'd0;
  localparam logic [WIDX_W-1:0] IDX_CNT_HI = 6'd1;
  localparam logic [WIDX_W-1:0] IDX_CMP0   = 6'd2;
  localparam logic [WIDX_W-1:0] IDX_STATUS = 6'd8;
  localparam logic [WIDX_W-1:0] IDX_IRQ_EN = 6'd9;
  localparam logic [WIDX_W-1:0] IDX_WDT_EN = 6'd10;
  localparam logic [WIDX_W-1:0] IDX_DIV    = 6'd11;
  localparam logic [WIDX_W-1:0] IDX_SNAP   = 6'd12;
  localparam logic [WIDX_W-1:0] IDX_SNP_LO = 6'd13;
  localparam logic [WIDX_W-1:0] IDX_SNP_HI = 6'd14;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] phase;
  logic [PC_W-1:0] limit;

  assign limit = {div, 1'b1};          // 2*(D+1) - 1
  assign tick  = !restart && (phase == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)       phase <= '0;
    else if (phase == limit)  phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  // R2: period is at least two clocks, so ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              snap,
  output logic [2*HALF_W-1:0] count,
  output logic [2*HALF_W-1:0] shadow,
  output logic              inc,
  output logic [HALF_W-1:0] next_lo
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] bumped;

  assign inc     = tick && !wr_lo && !wr_hi;
  assign bumped  = count + 1'b1;
  assign next_lo = bumped[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[HALF_W-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:HALF_W] <= wdata;
    end else if (tick) begin
      count <= bumped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (snap) shadow <= count;
  end

  // R3: an idle cycle leaves the counter alone
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo && !wr_hi) |=> $stable(count));
  // R3: a tick without a write advances by exactly one, with carry
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));
  // R4: the snapshot only moves on a command
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(shadow));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int NCH = 6,
  parameter int CW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          wr_ch,
  input  logic [CW-1:0]           wdata,
  input  logic                    inc,
  input  logic [CW-1:0]           next_lo,
  output logic [NCH-1:0][CW-1:0]  cmp_q,
  output logic [NCH-1:0]          hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           cmp_q[i] <= '0;
      else if (wr_ch[i]) cmp_q[i] <= wdata;
    end
    assign hit[i] = inc && (next_lo == cmp_q[i]);
  end
endmodule

// File: rtl/tmr_snapshot_timer.sv
module tmr_snapshot_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              wdt_rst
);
  localparam int WDT_CH = NUM_CH - 1;

  logic [WIDX_W-1:0]         widx;
  logic                      wr_lo, wr_hi, wr_stat, wr_ien, wr_wen, wr_div, snap;
  logic [NUM_CH-1:0]         wr_ch;
  logic [DATA_W-1:0]         div_q;
  logic                      tick, cnt_inc;
  logic [2*DATA_W-1:0]       count, shadow;
  logic [DATA_W-1:0]         next_lo;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp_q;
  logic [NUM_CH-1:0]         hit;
  logic [NUM_CH-1:0]         status, irq_en;
  logic                      wdt_en;
  logic [DATA_W-1:0]         rd_mux;

  assign widx    = addr[ADDR_W-1:2];
  assign wr_lo   = wr_en && widx == IDX_CNT_LO;
  assign wr_hi   = wr_en && widx == IDX_CNT_HI;
  assign wr_stat = wr_en && widx == IDX_STATUS;
  assign wr_ien  = wr_en && widx == IDX_IRQ_EN;
  assign wr_wen  = wr_en && widx == IDX_WDT_EN;
  assign wr_div  = wr_en && widx == IDX_DIV;
  assign snap    = wr_en && widx == IDX_SNAP && wdata[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wsel
    assign wr_ch[i] = wr_en && (widx == IDX_CMP0 + WIDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (wr_div) div_q <= wdata;
  end

  tmr_prescaler #(.DIV_W(DATA_W)) u_pre (
    .clk(clk), .rst(rst), .div(div_q), .restart(wr_div), .tick(tick)
  );

  tmr_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .snap(snap), .count(count), .shadow(shadow),
    .inc(cnt_inc), .next_lo(next_lo)
  );

  tmr_compare #(.NCH(NUM_CH), .CW(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_ch(wr_ch), .wdata(wdata), .inc(cnt_inc),
    .next_lo(next_lo), .cmp_q(cmp_q), .hit(hit)
  );

  // status: set on hit, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~(wr_stat ? wdata[NUM_CH-1:0] : '0)) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= '0;
      wdt_en <= 1'b0;
    end else begin
      if (wr_ien) irq_en <= wdata[NUM_CH-1:0];
      if (wr_wen) wdt_en <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        wdt_rst <= 1'b0;
    else if (wdt_en && hit[WDT_CH]) wdt_rst <= 1'b1;
  end

  assign irq = |(status & irq_en);

  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_CNT_LO: rd_mux = count[DATA_W-1:0];
      IDX_CNT_HI: rd_mux = count[2*DATA_W-1:DATA_W];
      IDX_STATUS: rd_mux = DATA_W'(status);
      IDX_IRQ_EN: rd_mux = DATA_W'(irq_en);
      IDX_WDT_EN: rd_mux = DATA_W'(wdt_en);
      IDX_DIV:    rd_mux = div_q;
      IDX_SNP_LO: rd_mux = shadow[DATA_W-1:0];
      IDX_SNP_HI: rd_mux = shadow[2*DATA_W-1:DATA_W];
      default:    rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++)
      if (widx == IDX_CMP0 + WIDX_W'(i)) rd_mux = cmp_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R9: the watchdog request never drops on its own
  a_r9_wdt_sticky: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> wdt_rst);
  // R9: the request only rises while the watchdog is armed
  a_r9_wdt_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> $past(wdt_en));
  // R6: no flag appears on a cycle without an increment
  a_r6_no_idle_set: assert property (@(posedge clk) disable iff (rst)
    !cnt_inc |=> ((status & ~$past(status)) == '0));
  // R7: a written 1 clears the flag unless the channel hits again
  a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[0] && !hit[0]) |=> !status[0]);
endmodule

// File: tb/sim_tmr_snapshot_timer.sv
module sim_tmr_snapshot_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq, wdt_rst;

  int total = 0, bad = 0;
  bit done = 0;
  logic pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] FREEZE = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  tmr_snapshot_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic bwr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic brd(logic [7:0] a, logic [31:0] e, string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rd_data, '0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    brd(8'h2C, 0, "R1 divider");
    brd(8'h20, 0, "R1 status");
    brd(8'h24, 0, "R1 irq enable");
    brd(8'h28, 0, "R1 wdt enable");
    brd(8'h34, 0, "R1 snapshot lo");
    brd(8'h38, 0, "R1 snapshot hi");
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 wdt_rst", {31'd0, wdt_rst}, 0);

    // R3/R4 direct write and snapshot
    bwr(8'h2C, FREEZE);
    bwr(8'h00, 32'h89AB_CDEF);
    bwr(8'h04, 32'h0123_4567);
    bwr(8'h30, 32'h1);
    brd(8'h34, 32'h89AB_CDEF, "R4 snapshot lo");
    brd(8'h38, 32'h0123_4567, "R4 snapshot hi");
    brd(8'h00, 32'h89AB_CDEF, "R3 live lo readback");
    bwr(8'h00, 32'h1111_1111);
    brd(8'h34, 32'h89AB_CDEF, "R4 snapshot holds");
    brd(8'h30, 0, "R4 command reads 0");
    brd(8'h3C, 0, "R10 unmapped reads 0");

    // R2 rate: D=1 -> 4 clocks per count; 40 clocks -> 10
    bwr(8'h00, 0);
    bwr(8'h04, 0);
    bwr(8'h2C, 32'd1);
    idle(40);
    bwr(8'h30, 32'h1);
    bwr(8'h2C, FREEZE);
    brd(8'h34, 32'd10, "R2 count after 40 clocks at D=1");
    brd(8'h38, 32'd0, "R2 high word");

    // R5 single match
    bwr(8'h00, 32'd99);
    bwr(8'h0C, 32'd100);
    bwr(8'h20, 32'h3F);
    bwr(8'h2C, 32'd0);
    idle(20);
    bwr(8'h2C, FREEZE);
    brd(8'h20, 32'h02, "R5 channel 1 match");
    // R7 zero write keeps, one write clears
    bwr(8'h20, 32'h0);
    brd(8'h20, 32'h02, "R7 write 0 keeps flag");
    // R8 irq gating
    check("R8 irq masked", {31'd0, irq}, 0);
    bwr(8'h24, 32'h02);
    check("R8 irq enabled", {31'd0, irq}, 1);
    bwr(8'h20, 32'h02);
    brd(8'h20, 32'h00, "R7 write 1 clears");
    check("R8 irq after clear", {31'd0, irq}, 0);
    bwr(8'h24, 32'h0);

    // R6 equal without increment
    bwr(8'h00, 32'd50);
    bwr(8'h10, 32'd50);
    idle(20);
    brd(8'h20, 32'h00, "R6 holding equal value sets nothing");

    // R5/R3 low-word wrap, carry into high word; channels 0,4,5 at 0, 3 at 2
    bwr(8'h00, FREEZE);
    bwr(8'h04, 32'd7);
    bwr(8'h14, 32'd2);
    bwr(8'h2C, 32'd0);
    idle(30);
    bwr(8'h2C, FREEZE);
    bwr(8'h30, 32'h1);
    brd(8'h38, 32'd8, "R3 carry into high word");
    brd(8'h20, 32'h39, "R5 matches across low-word wrap");
    check("R9 disarmed wdt_rst", {31'd0, wdt_rst}, 0);

    // R9 watchdog disarmed then armed
    bwr(8'h20, 32'h3F);
    bwr(8'h00, 32'd200);
    bwr(8'h1C, 32'd203);
    bwr(8'h2C, 32'd0);
    idle(20);
    bwr(8'h2C, FREEZE);
    brd(8'h20, 32'h20, "R9 channel 5 flag while disarmed");
    check("R9 no reset while disarmed", {31'd0, wdt_rst}, 0);
    bwr(8'h28, 32'h1);
    bwr(8'h00, 32'd200);
    bwr(8'h2C, 32'd0);
    idle(20);
    bwr(8'h2C, FREEZE);
    check("R9 armed reset", {31'd0, wdt_rst}, 1);
    idle(5);
    check("R9 reset sticky", {31'd0, wdt_rst}, 1);

    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 wdt_rst after reset", {31'd0, wdt_rst}, 0);
    brd(8'h28, 0, "R1 wdt enable after reset");

    idle(3);
    if (exp_q.size() != 0) check("R10 pending reads", exp_q.size(), 0);
    finish_run();
  end
endmodule